// File: doc/BRIEF.md
# Gated Concatenable Event Counter Bank

This block totals pulse events on four input lines. Each line passes through its own gate qualifier, a clock-domain synchronizer and a rising-edge detector, and then drives a 16-bit binary counter. The gate qualifier can be switched on or off for each channel. When it is on, an event counts only while that channel's gate input is high. When it is off, the gate pin has no effect.

Two static fuse bits can join a pair of neighbouring channels into one 32-bit totalizer. One bit joins channels 0 and 1, the other joins channels 2 and 3. In a joined pair the even channel holds the low half and the odd channel holds the high half. The odd channel's own input is then ignored, and the high half advances only on a carry out of the low half. Any single channel can be zeroed on request. Zeroing the low half of a joined pair also zeroes its high half. The global reset clears only the synchronizers and never touches a count, so software must zero a channel before it trusts that channel's value.

Top module: `evtcnt_bank`

## Requirements
- R1: A rising edge on a channel's qualified input adds exactly one to that channel's count. The new value appears on `count_o` after the third rising clock edge that follows the input change: two synchronizer flops, then the counter register.
- R2: An input held high for many cycles adds only one to the count.
- R3: With `gate_en[i]`=1, the qualified input of channel i is `evt_in[i] & gate_in[i]`. An event that arrives while the gate is low adds nothing.
- R4: With `gate_en[i]`=0, the qualified input is `evt_in[i]` alone, and `gate_in[i]` has no effect.
- R5: With a pair unfused, each 16-bit counter wraps from 0xFFFF to 0x0000 and does not disturb its neighbour.
- R6: With a pair fused (`pair_fuse[0]` joins channels 0/1, `pair_fuse[1]` joins channels 2/3), the odd channel advances by one exactly when the even channel wraps from 0xFFFF to 0x0000. The odd channel's own input is ignored.
- R7: With `clr_valid`=1 and `clr_ch`=i at a clock edge, channel i reads zero after that edge. Unfused channels that were not named keep their values.
- R8: In a fused pair, a clear of the even channel also zeroes the odd channel.
- R9: When a clear and an increment reach the same counter in the same cycle, the clear wins and the counter reads zero.
- R10: Asserting or releasing `rst_n` leaves every count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low reset; clears the synchronizers only |
| evt_in | input | 4 | Event pulse input, one bit per channel |
| gate_in | input | 4 | External gate, one bit per channel |
| gate_en | input | 4 | 1 = the channel's gate qualifies its event |
| pair_fuse | input | 2 | Bit 0 joins channels 0/1, bit 1 joins channels 2/3 |
| clr_valid | input | 1 | Clear request strobe |
| clr_ch | input | 2 | Channel to clear (0 to 3) |
| count_o | output | 64 | Live counts; channel i occupies bits [16*i+15:16*i] |

## Verification
An event driven just before clock edge k appears in the count after edge k+2. The bench drives each event on a falling edge, holds it for one cycle, waits three more falling edges and only then compares all four counts. A clear strobe takes effect at the edge where it is sampled. Clear results are therefore checked at the next falling edge, and checked again a few cycles later so that a delayed increment cannot slip through. For the wrap and carry cases, 65536 events are fed to channels 0 and 2 at one event every two cycles, and the result is read after the last event has passed the three-edge pipeline.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
    localparam int NUM_CH    = 4;
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int CH_IDX_W  = $clog2(NUM_CH);
endpackage

// File: rtl/evtcnt_edge.sv
module evtcnt_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], din};
        st_d.last = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.sync[STAGES-1] & ~st_q.last;

    // R2: a detected edge never lasts two cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/evtcnt_pair.sv
module evtcnt_pair #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fuse,
    input  logic          rise_lo,
    input  logic          rise_hi,
    input  logic          clr_lo,
    input  logic          clr_hi,
    output logic [CW-1:0] cnt_lo,
    output logic [CW-1:0] cnt_hi
);
    localparam logic [CW-1:0] ALL_ONES = '1;
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] lo;
        logic [CW-1:0] hi;
    } pair_state_t;

    pair_state_t st_d, st_q;
    logic        hi_step;
    logic        hi_zero;

    always_comb begin
        st_d    = st_q;
        hi_step = fuse ? (rise_lo && (st_q.lo == ALL_ONES)) : rise_hi;
        hi_zero = clr_hi || (fuse && clr_lo);
        if (clr_lo)       st_d.lo = '0;
        else if (rise_lo) st_d.lo = st_q.lo + ONE;
        if (hi_zero)      st_d.hi = '0;
        else if (hi_step) st_d.hi = st_q.hi + ONE;
    end

    // Counts survive the global reset on purpose.
    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_lo = st_q.lo;
    assign cnt_hi = st_q.hi;

    // Track which halves hold a defined value, for the step checks only.
    logic lo_known_q, hi_known_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_known_q <= 1'b0;
            hi_known_q <= 1'b0;
        end else begin
            if (clr_lo)                    lo_known_q <= 1'b1;
            if (clr_hi || (fuse && clr_lo)) hi_known_q <= 1'b1;
        end
    end

    a_r7_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lo |=> cnt_lo == '0);
    a_r7_clear_hi: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hi |=> cnt_hi == '0);
    a_r8_fused_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse && clr_lo) |=> cnt_hi == '0);
    a_r1_lo_step: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_known_q && !clr_lo) |=>
            (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + ONE));
    a_r6_carry_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse && lo_known_q && hi_known_q && !clr_lo && !clr_hi) |=>
            (cnt_hi == $past(cnt_hi)) ||
            (($past(cnt_lo) == ALL_ONES) && (cnt_lo == '0)));
endmodule

// File: rtl/evtcnt_bank.sv
module evtcnt_bank
    import evtcnt_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    evt_in,
    input  logic [NUM_CH-1:0]    gate_in,
    input  logic [NUM_CH-1:0]    gate_en,
    input  logic [NUM_PAIRS-1:0] pair_fuse,
    input  logic                 clr_valid,
    input  logic [CH_IDX_W-1:0]  clr_ch,
    output logic [NUM_CH*CW-1:0] count_o
);
    logic [NUM_CH-1:0] qual;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] clr_vec;

    assign qual = evt_in & (gate_in | ~gate_en);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign clr_vec[c] = clr_valid && (clr_ch == CH_IDX_W'(c));

        evtcnt_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (qual[c]),
            .rise (rise[c])
        );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        evtcnt_pair #(.CW(CW)) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .fuse   (pair_fuse[p]),
            .rise_lo(rise[2*p]),
            .rise_hi(rise[2*p+1]),
            .clr_lo (clr_vec[2*p]),
            .clr_hi (clr_vec[2*p+1]),
            .cnt_lo (count_o[(2*p)*CW +: CW]),
            .cnt_hi (count_o[(2*p+1)*CW +: CW])
        );
    end

    // R7: one request names at most one channel
    a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: tb/evtcnt_bank_bench.sv
module evtcnt_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_in = '0;
    logic [3:0]  gate_in = '0;
    logic [3:0]  gate_en = '0;
    logic [1:0]  pair_fuse = '0;
    logic        clr_valid = 1'b0;
    logic [1:0]  clr_ch = '0;
    logic [63:0] count_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [CW-1:0] exp_cnt [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    evtcnt_bank u_evtcnt_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .gate_in(gate_in),
        .gate_en(gate_en), .pair_fuse(pair_fuse), .clr_valid(clr_valid),
        .clr_ch(clr_ch), .count_o(count_o)
    );

    // {evt, gate, gate_en, expected increment per channel}
    localparam logic [15:0] VEC [8] = '{
        16'b0001_0000_0000_0001,   // R1 single channel
        16'b1111_0000_0000_1111,   // R4 gates off, gate pins low
        16'b1111_0000_1111_0000,   // R3 gates on and closed
        16'b1111_1010_1111_1010,   // R3 partly open
        16'b1111_0101_0011_1101,   // R3 R4 mixed
        16'b0110_1111_1111_0110,   // R1 R3 open gates
        16'b1000_0000_0111_1000,   // R4 ch3 ungated
        16'b0000_1111_1111_0000    // R1 no event
    };

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            n_checks++;
            if (count_o[i*CW +: CW] !== exp_cnt[i]) begin
                n_fail++;
                $display("FAIL %s ch%0d actual %h expected %h", tag, i,
                         count_o[i*CW +: CW], exp_cnt[i]);
            end
        end
    endtask

    task automatic pulse(input logic [3:0] evt);
        @(negedge clk); evt_in = evt;
        @(negedge clk); evt_in = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clear(input logic [1:0] ch);
        @(negedge clk); clr_valid = 1'b1; clr_ch = ch;
        @(negedge clk); clr_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: zero every channel, one request each
        for (int c = 0; c < 4; c++) clear(2'(c));
        for (int c = 0; c < 4; c++) exp_cnt[c] = '0;
        @(negedge clk);
        check_all("R7 initial clear");

        // Table of gating patterns (R1 R3 R4)
        for (int v = 0; v < 8; v++) begin
            gate_in = VEC[v][11:8];
            gate_en = VEC[v][7:4];
            pulse(VEC[v][15:12]);
            for (int c = 0; c < 4; c++) exp_cnt[c] += CW'(VEC[v][c]);
            check_all($sformatf("R1 R3 R4 vector %0d", v));
        end
        gate_en = '0;

        // R2: level held high counts once
        @(negedge clk); evt_in = 4'b0001;
        repeat (12) @(negedge clk);
        evt_in = '0;
        repeat (3) @(negedge clk);
        exp_cnt[0] += 1;
        check_all("R2 held level");

        // R7: clearing ch2 leaves the others alone
        clear(2'd2);
        exp_cnt[2] = '0;
        check_all("R7 single clear");

        // R10: reset leaves counts unchanged
        @(negedge clk); rst_n = 1'b0;
        repeat (4) @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_all("R10 reset keeps counts");

        // R9: clear coincides with increment on ch1
        @(negedge clk); evt_in = 4'b0010;
        @(negedge clk); evt_in = '0;
        @(negedge clk); clr_valid = 1'b1; clr_ch = 2'd1;
        @(negedge clk); clr_valid = 1'b0;
        exp_cnt[1] = '0;
        check_all("R9 clear beats increment");
        repeat (4) @(negedge clk);
        check_all("R9 no late increment");

        // R5 R6: wrap ch2 alone and ch0 into fused ch1
        pair_fuse = 2'b01;
        for (int c = 0; c < 4; c++) clear(2'(c));
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk); evt_in = 4'b0101;
            @(negedge clk); evt_in = '0;
        end
        repeat (4) @(negedge clk);
        exp_cnt[0] = '0; exp_cnt[1] = 16'h0001;
        exp_cnt[2] = '0; exp_cnt[3] = '0;
        check_all("R5 R6 wrap and carry");

        // R6: fused upper ignores its own input
        pulse(4'b0010);
        check_all("R6 upper input ignored");

        // R8: clearing fused lower zeroes upper too
        pulse(4'b0001);
        exp_cnt[0] = 16'h0001;
        check_all("R6 lower step");
        clear(2'd0);
        exp_cnt[0] = '0; exp_cnt[1] = '0;
        check_all("R8 fused clear");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule